// File: doc/BRIEF.md
# Nibble-Serial Decimal Register ALU

This block is the word-arithmetic engine of a small calculator-style processor. It keeps a bank of working registers, each made of `NIBBLES` binary-coded-decimal digits, in a multi-ported register array. On request it walks a chosen digit field of a destination register and a source register. The walk goes one digit at a time, from the lowest index of the field to the highest. On each digit it applies one of six operations: decimal add, decimal subtract, copy, exchange, clear or load-constant. A decimal carry or borrow passes from digit to digit and is reported when the operation finishes.

Control is plain pulse/level signalling, because no data stream crosses the block's edge. A one-cycle `start` with an operation code, two register selects and a first/last digit index launches the work. `busy` stays high while the sequencer runs. `done` pulses once at the end, and the final carry appears with it. The caller has no back-pressure to apply, and the block offers none. A request made while busy is simply dropped. Each digit costs two cycles: a read cycle and a compute/write cycle. A full-width word on the default 14 digits therefore takes 33 cycles.

A separate read port lets a display consumer fetch the same digit index from two fixed registers, A and B, in every cycle. It has no effect on the arithmetic and never stalls it.

Top module: `dec_nib_alu`

## Requirements
- R1: While `rst_n` is low and after it is released, `busy`, `done` and `carry_out` are 0 until a request is accepted.
- R2: Op code 0 (add) writes dst[i] = (dst[i] + src[i] + c) mod 10 for each digit i of the field, taken in ascending order. c starts at 0 and becomes 1 when the digit sum reaches 10. The final c is reported on `carry_out`.
- R3: Op code 1 (subtract) writes dst[i] = dst[i] − src[i] − b, adding 10 when that value is negative. b starts at 0 and becomes 1 when the 10 was added. The final b is reported on `carry_out`.
- R4: Op code 2 copies src into dst. Op code 3 exchanges dst and src, and leaves the register unchanged when both selects are equal. Op code 4 writes 0. Op code 5 writes `load_digit`. These four report `carry_out` = 0.
- R5: Only digits `first_nib` through `last_nib` of the registers concerned are written. All other digits keep their values.
- R6: `done` is first seen high after exactly 2·n + 5 rising edges counted from the edge that accepts `start`, where n = `last_nib` − `first_nib` + 1. This is 33 for a full 14-digit word.
- R7: `done` is high for exactly one cycle. `busy` falls on the same edge. `carry_out` keeps its value until the next completion.
- R8: A `start` pulse while `busy` is high is ignored, along with any change of the other request inputs. The running operation's result and timing are unchanged.
- R9: A `start` with op code 6 or 7, with `first_nib` > `last_nib`, with `last_nib` ≥ `NIBBLES`, or with a register select ≥ `NREGS` is ignored. `busy` stays low, no `done` follows, and no register changes.
- R10: `disp_a` and `disp_b` show digit `disp_idx` of registers `DISP_A` and `DISP_B` one cycle after `disp_idx` is presented. This holds in every cycle, including while an operation runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe |
| op | input | 3 | Operation code (0 add, 1 sub, 2 copy, 3 exchange, 4 clear, 5 load) |
| dst_sel | input | $clog2(NREGS) | Destination register |
| src_sel | input | $clog2(NREGS) | Source register |
| first_nib | input | $clog2(NIBBLES) | Lowest digit index of the field |
| last_nib | input | $clog2(NIBBLES) | Highest digit index of the field |
| load_digit | input | 4 | Constant for the load operation |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| carry_out | output | 1 | Final decimal carry/borrow |
| disp_idx | input | $clog2(NIBBLES) | Digit index for the display port |
| disp_a | output | 4 | Digit of register DISP_A |
| disp_b | output | 4 | Digit of register DISP_B |

## Verification
The bench keeps `NIBBLES` at 14, so the full-word 33-cycle latency and the all-nines carry ripple across every digit are exercised exactly. It lowers `NREGS` to 4. With only four registers, random selects often make source and destination equal, often target the two display registers, and let the copy-to-A path observe every register in the bank. The bench also issues single-digit fields, which reach the shortest 7-cycle case.

// File: rtl/dec_nib_pkg.sv
package dec_nib_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_COPY = 3'd2,
    OP_EXCH = 3'd3,
    OP_CLR  = 3'd4,
    OP_LOAD = 3'd5
  } nib_op_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_SETUP,
    S_READ,
    S_WRITE,
    S_TAIL
  } seq_state_e;

  // returns {carry, digit}
  function automatic logic [4:0] bcd_add(logic [3:0] a, logic [3:0] b, logic c);
    logic [4:0] s;
    s = {1'b0, a} + {1'b0, b} + {4'b0, c};
    if (s >= 5'd10) return {1'b1, 4'(s - 5'd10)};
    return {1'b0, s[3:0]};
  endfunction

  // returns {borrow, digit}
  function automatic logic [4:0] bcd_sub(logic [3:0] a, logic [3:0] b, logic c);
    logic [4:0] d;
    d = {1'b0, a} - {1'b0, b} - {4'b0, c};
    if (d[4]) return {1'b1, 4'(d + 5'd10)};
    return {1'b0, d[3:0]};
  endfunction

endpackage

// File: rtl/nib_regfile.sv
module nib_regfile #(
  parameter int NREGS   = 8,
  parameter int NIBBLES = 14,
  parameter int DISP_A  = 0,
  parameter int DISP_B  = 1,
  localparam int RW = $clog2(NREGS),
  localparam int NW = $clog2(NIBBLES)
) (
  input  logic          clk,
  input  logic [RW-1:0] rx_reg,
  input  logic [NW-1:0] rx_nib,
  output logic [3:0]    rx_q,
  input  logic [RW-1:0] ry_reg,
  input  logic [NW-1:0] ry_nib,
  output logic [3:0]    ry_q,
  input  logic          w0_en,
  input  logic [RW-1:0] w0_reg,
  input  logic [NW-1:0] w0_nib,
  input  logic [3:0]    w0_d,
  input  logic          w1_en,
  input  logic [RW-1:0] w1_reg,
  input  logic [NW-1:0] w1_nib,
  input  logic [3:0]    w1_d,
  input  logic [NW-1:0] dn,
  output logic [3:0]    da_q,
  output logic [3:0]    db_q
);
  localparam int NDISP = 2;
  localparam int DREG [NDISP] = '{DISP_A, DISP_B};

  logic [3:0] mem [NREGS][NIBBLES];

  always_ff @(posedge clk) begin
    if (w0_en) mem[w0_reg][w0_nib] <= w0_d;
    if (w1_en) mem[w1_reg][w1_nib] <= w1_d;
  end

  always_ff @(posedge clk) begin
    rx_q <= mem[rx_reg][rx_nib];
    ry_q <= mem[ry_reg][ry_nib];
  end

  for (genvar g = 0; g < NDISP; g++) begin : g_disp
    logic [3:0] q;
    always_ff @(posedge clk) q <= mem[DREG[g]][dn];
  end

  assign da_q = g_disp[0].q;
  assign db_q = g_disp[1].q;

endmodule

// File: rtl/bcd_nib_alu.sv
module bcd_nib_alu
  import dec_nib_pkg::*;
(
  input  nib_op_e    op,
  input  logic [3:0] src_d,
  input  logic [3:0] dst_d,
  input  logic [3:0] k,
  input  logic       cin,
  output logic [3:0] dst_o,
  output logic [3:0] src_o,
  output logic       src_we,
  output logic       cout
);
  logic [4:0] sum_r, dif_r;

  always_comb begin
    sum_r  = bcd_add(dst_d, src_d, cin);
    dif_r  = bcd_sub(dst_d, src_d, cin);
    dst_o  = dst_d;
    src_o  = src_d;
    src_we = 1'b0;
    cout   = 1'b0;
    case (op)
      OP_ADD:  begin dst_o = sum_r[3:0]; cout = sum_r[4]; end
      OP_SUB:  begin dst_o = dif_r[3:0]; cout = dif_r[4]; end
      OP_COPY: dst_o = src_d;
      OP_EXCH: begin dst_o = src_d; src_o = dst_d; src_we = 1'b1; end
      OP_CLR:  dst_o = 4'd0;
      OP_LOAD: dst_o = k;
      default: dst_o = dst_d;
    endcase
  end

endmodule

// File: rtl/nib_seq.sv
module nib_seq
  import dec_nib_pkg::*;
#(
  parameter int NIBBLES = 14,
  parameter int TAIL    = 4,
  localparam int NW = $clog2(NIBBLES),
  localparam int TW = $clog2(TAIL) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          req_ok,
  input  logic [NW-1:0] first,
  input  logic [NW-1:0] last,
  input  logic          alu_cout,
  output logic          accept,
  output logic [NW-1:0] idx,
  output logic          wr_en,
  output logic          carry_q,
  output logic          busy,
  output logic          done,
  output logic          carry_out
);
  seq_state_e    state;
  logic [NW-1:0] last_q;
  logic [TW-1:0] tail_cnt;

  assign accept = (state == S_IDLE) && start && req_ok;
  assign busy   = (state != S_IDLE);
  assign wr_en  = (state == S_WRITE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      last_q    <= '0;
      tail_cnt  <= '0;
      carry_q   <= 1'b0;
      done      <= 1'b0;
      carry_out <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          state   <= S_SETUP;
          idx     <= first;
          last_q  <= last;
          carry_q <= 1'b0;
        end
        S_SETUP: state <= S_READ;
        S_READ:  state <= S_WRITE;
        S_WRITE: begin
          carry_q <= alu_cout;
          if (idx == last_q) begin
            state    <= S_TAIL;
            tail_cnt <= '0;
          end else begin
            idx   <= idx + 1'b1;
            state <= S_READ;
          end
        end
        S_TAIL: begin
          if (tail_cnt == TW'(TAIL - 1)) begin
            state     <= S_IDLE;
            done      <= 1'b1;
            carry_out <= carry_q;
          end else begin
            tail_cnt <= tail_cnt + 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dec_nib_alu.sv
module dec_nib_alu
  import dec_nib_pkg::*;
#(
  parameter int NIBBLES = 14,
  parameter int NREGS   = 8,
  parameter int DISP_A  = 0,
  parameter int DISP_B  = 1,
  parameter int TAIL    = 4,
  localparam int RW = $clog2(NREGS),
  localparam int NW = $clog2(NIBBLES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [2:0]    op,
  input  logic [RW-1:0] dst_sel,
  input  logic [RW-1:0] src_sel,
  input  logic [NW-1:0] first_nib,
  input  logic [NW-1:0] last_nib,
  input  logic [3:0]    load_digit,
  output logic          busy,
  output logic          done,
  output logic          carry_out,
  input  logic [NW-1:0] disp_idx,
  output logic [3:0]    disp_a,
  output logic [3:0]    disp_b
);
  logic          req_ok, accept, wr_en, carry_q, alu_cout, src_we;
  logic [NW-1:0] idx;
  nib_op_e       op_q;
  logic [RW-1:0] dst_q, src_q;
  logic [3:0]    k_q, rx_q, ry_q, dst_o, src_o;

  assign req_ok = (int'(op) <= int'(OP_LOAD)) && (first_nib <= last_nib)
               && (int'(last_nib) < NIBBLES)
               && (int'(dst_sel) < NREGS) && (int'(src_sel) < NREGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= OP_ADD;
      dst_q <= '0;
      src_q <= '0;
      k_q   <= '0;
    end else if (accept) begin
      op_q  <= nib_op_e'(op);
      dst_q <= dst_sel;
      src_q <= src_sel;
      k_q   <= load_digit;
    end
  end

  nib_seq #(.NIBBLES(NIBBLES), .TAIL(TAIL)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .req_ok(req_ok),
    .first(first_nib), .last(last_nib), .alu_cout(alu_cout),
    .accept(accept), .idx(idx), .wr_en(wr_en), .carry_q(carry_q),
    .busy(busy), .done(done), .carry_out(carry_out)
  );

  nib_regfile #(.NREGS(NREGS), .NIBBLES(NIBBLES), .DISP_A(DISP_A), .DISP_B(DISP_B)) u_rf (
    .clk(clk),
    .rx_reg(src_q), .rx_nib(idx), .rx_q(rx_q),
    .ry_reg(dst_q), .ry_nib(idx), .ry_q(ry_q),
    .w0_en(wr_en), .w0_reg(dst_q), .w0_nib(idx), .w0_d(dst_o),
    .w1_en(wr_en && src_we), .w1_reg(src_q), .w1_nib(idx), .w1_d(src_o),
    .dn(disp_idx), .da_q(disp_a), .db_q(disp_b)
  );

  bcd_nib_alu u_alu (
    .op(op_q), .src_d(rx_q), .dst_d(ry_q), .k(k_q), .cin(carry_q),
    .dst_o(dst_o), .src_o(src_o), .src_we(src_we), .cout(alu_cout)
  );

endmodule

// File: rtl/dec_nib_alu_chk.sv
module dec_nib_alu_chk #(
  parameter int NIBBLES = 14,
  parameter int NREGS   = 8,
  localparam int RW = $clog2(NREGS),
  localparam int NW = $clog2(NIBBLES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [2:0]    op,
  input logic [RW-1:0] dst_sel,
  input logic [RW-1:0] src_sel,
  input logic [NW-1:0] first_nib,
  input logic [NW-1:0] last_nib,
  input logic          busy,
  input logic          done,
  input logic          carry_out
);
  logic       take;
  int         cyc, exp_len;
  logic [2:0] op_seen;

  assign take = start && !busy && (op <= 3'd5) && (first_nib <= last_nib)
             && (int'(last_nib) < NIBBLES)
             && (int'(dst_sel) < NREGS) && (int'(src_sel) < NREGS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc     <= 0;
      exp_len <= 0;
      op_seen <= '0;
    end else if (take) begin
      cyc     <= 0;
      exp_len <= 2 * (int'(last_nib) - int'(first_nib) + 1) + 5;
      op_seen <= op;
    end else if (busy) begin
      cyc <= cyc + 1;
    end
  end

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R8
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R6
  latency_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> (cyc == exp_len));
  // R4
  no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && op_seen >= 3'd2) |-> !carry_out);
  // R7
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(carry_out));

endmodule

bind dec_nib_alu dec_nib_alu_chk #(.NIBBLES(NIBBLES), .NREGS(NREGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst_sel(dst_sel),
  .src_sel(src_sel), .first_nib(first_nib), .last_nib(last_nib),
  .busy(busy), .done(done), .carry_out(carry_out)
);

// File: tb/test_dec_nib_alu.sv
module test_dec_nib_alu;
  localparam int NB = 14;
  localparam int NR = 4;
  localparam int RW = $clog2(NR);
  localparam int NW = $clog2(NB);

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [2:0] op = '0;
  logic [RW-1:0] dst = '0, src = '0;
  logic [NW-1:0] fst = '0, lst = '0, didx = '0;
  logic [3:0] kd = '0;
  logic busy, done, carry_out;
  logic [3:0] disp_a, disp_b;

  int checks = 0, fails = 0;
  int mdl [NR][NB];

  always #2 clk = ~clk;

  dec_nib_alu #(.NIBBLES(NB), .NREGS(NR)) i_dec_nib_alu (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .dst_sel(dst),
    .src_sel(src), .first_nib(fst), .last_nib(lst), .load_digit(kd),
    .busy(busy), .done(done), .carry_out(carry_out),
    .disp_idx(didx), .disp_a(disp_a), .disp_b(disp_b)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [4*NB-1:0] mword(int r);
    logic [4*NB-1:0] w;
    for (int i = 0; i < NB; i++) w[4*i +: 4] = 4'(mdl[r][i]);
    return w;
  endfunction

  task automatic read_ab(output logic [4*NB-1:0] wa, output logic [4*NB-1:0] wb);
    for (int i = 0; i < NB; i++) begin
      @(negedge clk) didx = NW'(i);
      @(negedge clk);
      wa[4*i +: 4] = disp_a;
      wb[4*i +: 4] = disp_b;
    end
  endtask

  task automatic check_ab(input string tag);
    logic [4*NB-1:0] wa, wb;
    read_ab(wa, wb);
    chk(wa == mword(0), {tag, " regA"}, longint'(wa), longint'(mword(0)));
    chk(wb == mword(1), {tag, " regB"}, longint'(wb), longint'(mword(1)));
  endtask

  // apply op to model, return expected carry
  function automatic int model_op(int opc, int d, int s, int f, int l, int k);
    int c = 0;
    for (int i = f; i <= l; i++) begin
      int a = mdl[d][i];
      int b = mdl[s][i];
      int t = a;
      case (opc)
        0: begin t = a + b + c; c = (t >= 10); if (c != 0) t -= 10; end
        1: begin t = a - b - c; c = (t < 0); if (c != 0) t += 10; end
        2, 3: t = b;
        4: t = 0;
        default: t = k;
      endcase
      mdl[d][i] = t;
      if (opc == 3) mdl[s][i] = a;
    end
    return (opc <= 1) ? c : 0;
  endfunction

  task automatic run_op(input int opc, input int d, input int s, input int f,
                        input int l, input int k, input bit poke, input string tag);
    int expc, cnt;
    expc = model_op(opc, d, s, f, l, k);
    @(negedge clk);
    op = 3'(opc); dst = RW'(d); src = RW'(s); fst = NW'(f); lst = NW'(l); kd = 4'(k);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cnt = 0;
    while (!done && cnt < 200) begin
      if (poke && cnt == 2) begin
        start = 1'b1; op = 3'd4; dst = '0; fst = '0; lst = NW'(NB - 1);
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      cnt++;
    end
    start = 1'b0;
    chk(cnt == 2 * (l - f + 1) + 5, poke ? "R8 latency" : "R6 latency", cnt, 2 * (l - f + 1) + 5);
    chk(carry_out == expc[0], {tag, " carry"}, carry_out, expc);
    @(negedge clk);
    chk(!done && !busy && carry_out == expc[0], "R7 done pulse/hold",
        {done, busy, carry_out}, {2'b00, expc[0]});
    check_ab(poke ? "R8" : tag);
  endtask

  task automatic try_bad(input int opc, input int f, input int l);
    bit seen = 0;
    @(negedge clk);
    op = 3'(opc); dst = '0; src = 1; fst = NW'(f); lst = NW'(l); kd = 4'd7;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    for (int i = 0; i < 40; i++) begin
      if (busy || done) seen = 1;
      @(negedge clk);
    end
    chk(!seen, "R9 ignored request", seen, 0);
    check_ab("R9");
  endtask

  task automatic load_word(input int r, input logic [4*NB-1:0] w);
    for (int i = 0; i < NB; i++) begin
      int cdummy;
      cdummy = model_op(5, r, r, i, i, int'(w[4*i +: 4]));
      @(negedge clk);
      op = 3'd5; dst = RW'(r); src = RW'(r); fst = NW'(i); lst = NW'(i); kd = w[4*i +: 4];
      start = 1'b1;
      @(negedge clk) start = 1'b0;
      while (!done) @(negedge clk);
    end
  endtask

  task automatic disp_during_op();
    int cnt = 0;
    int cur = 0;
    void'(model_op(0, 2, 3, 0, NB - 1, 0));
    @(negedge clk);
    op = 3'd0; dst = 2; src = 3; fst = '0; lst = NW'(NB - 1); didx = '0;
    start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!done && cnt < 200) begin
      chk(disp_a == 4'(mdl[0][cur]) && disp_b == 4'(mdl[1][cur]), "R10 display while busy",
          {disp_a, disp_b}, {4'(mdl[0][cur]), 4'(mdl[1][cur])});
      cur = (cur + 1) % NB;
      didx = NW'(cur);
      @(negedge clk);
      cnt++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R6 watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [4*NB-1:0] nines, one;
    void'($urandom(32'h5eed_1234));
    for (int r = 0; r < NR; r++) for (int i = 0; i < NB; i++) mdl[r][i] = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !carry_out, "R1 in reset", {busy, done, carry_out}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && !carry_out, "R1 after reset", {busy, done, carry_out}, 0);

    for (int r = 0; r < NR; r++) run_op(4, r, r, 0, NB - 1, 0, 0, "R4 clear");

    for (int i = 0; i < NB; i++) begin
      nines[4*i +: 4] = 4'd9;
      one[4*i +: 4] = (i == 0) ? 4'd1 : 4'd0;
    end
    load_word(0, nines);
    load_word(1, one);
    run_op(0, 0, 1, 0, NB - 1, 0, 0, "R2 full ripple add");
    run_op(1, 0, 1, 0, NB - 1, 0, 0, "R3 full ripple borrow");
    run_op(0, 1, 0, 0, NB - 1, 0, 0, "R2 add into B");
    run_op(0, 0, 1, 3, 6, 0, 0, "R5 partial add");
    run_op(1, 1, 0, 5, 5, 0, 0, "R5 single digit sub");
    run_op(3, 0, 1, 0, NB - 1, 0, 0, "R4 exchange");
    run_op(3, 1, 1, 2, 9, 0, 0, "R4 exchange self");
    run_op(2, 0, 1, 4, 12, 0, 0, "R5 partial copy");
    run_op(5, 1, 0, 13, 13, 6, 0, "R4 load top digit");
    run_op(0, 0, 1, 0, NB - 1, 0, 1, "R8 start while busy");
    try_bad(6, 0, NB - 1);
    try_bad(7, 0, 3);
    try_bad(0, 5, 2);
    try_bad(0, 0, NB);
    disp_during_op();

    for (int n = 0; n < 160; n++) begin
      int opc = (n < 40) ? 5 : int'($urandom_range(0, 5));
      int f = int'($urandom_range(0, NB - 1));
      int l = int'($urandom_range(f, NB - 1));
      int d = int'($urandom_range(0, NR - 1));
      int s = int'($urandom_range(0, NR - 1));
      string tg;
      if (n % 9 == 8) begin opc = 2; d = 0; f = 0; l = NB - 1; end
      case (opc)
        0: tg = "R2 random add";
        1: tg = "R3 random sub";
        default: tg = "R4 random data op";
      endcase
      if (f != 0 || l != NB - 1) tg = {tg, " R5"};
      run_op(opc, d, s, f, l, int'($urandom_range(0, 9)), ($urandom_range(0, 7) == 0), tg);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule